// File: doc/BRIEF.md
# Oversampled Serial Receiver with Line Error Flags

This block turns an asynchronous serial stream into parallel characters. A free-running clock `clk` is qualified by `tickEn`, which pulses sixteen times per bit period. On each tick the receiver watches `serialIn`, which idles high. A falling edge opens a start-bit check. If the start bit holds, the data bits are sampled least significant bit first, then an optional parity bit and one stop bit. The finished character is then copied from the internal shift register into a separate holding buffer `rxData`. The next character can arrive while the CPU still has the previous one.

The frame format is set by `wordLen` (5 to 8 data bits) and by `parityOn` and `parityEven`. The block raises `dataReady` when a character lands in the buffer. It flags overrun, parity, framing and break conditions for the surrounding line-status and interrupt logic. `rdStrobe` marks a CPU read of the buffer and `errClear` marks a read of the status that consumes the error flags. `serialIn` is taken to be synchronous to `clk`.

Top module: `uart_rx_core`

## Requirements
- R1: While `rstN` is low, `rxData` is zero and `dataReady`, `overrunErr`, `parityErr`, `framingErr` and `breakInt` are all low.
- R2: A low level seen on `serialIn` at a tick in idle starts a start-bit check. The start bit is accepted only if `serialIn` is still low 8 ticks later. Otherwise the receiver returns to idle and no character is produced.
- R3: Each data, parity and stop bit is sampled once, 16 ticks after the previous sample, so that it falls in the middle of its bit time. Line noise confined to the first and last quarter of a bit has no effect.
- R4: `wordLen` selects the data width as 0→5, 1→6, 2→7 and 3→8 bits. Data arrive least significant bit first and are placed right-justified in `rxData`, with unused upper bits zero.
- R5: With `parityOn` high, one parity bit follows the data. `parityEven`=1 selects even parity and 0 selects odd parity. A mismatch sets `parityErr`. With `parityOn` low, no parity bit is expected and `parityErr` is never set.
- R6: `framingErr` is set when the stop bit is sampled low.
- R7: `breakInt` is set when the start bit, all data bits, the parity bit (if enabled) and the stop bit are all sampled low. A break frame therefore also sets `framingErr` and loads a zero character.
- R8: `dataReady` is set in the cycle after a character completes and is cleared by `rdStrobe`. When a completion and `rdStrobe` share a cycle, the read takes the old character and `dataReady` stays set.
- R9: A completion while `dataReady` is set, and not accompanied by `rdStrobe` in the same cycle, sets `overrunErr`. The new character replaces the buffer contents.
- R10: The four error flags stay set until `errClear`, and `rdStrobe` does not clear them. When a new error and `errClear` fall in the same cycle, the flag ends up set.
- R11: The receiver advances only on cycles with `tickEn` high. With ticks spaced several clocks apart, characters are received correctly and `rxData` never changes on a cycle without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Oversampling enable, 16 pulses per bit |
| serialIn | input | 1 | Serial line, idle high |
| wordLen | input | 2 | Data width select, 0..3 → 5..8 bits |
| parityOn | input | 1 | Parity bit present |
| parityEven | input | 1 | 1 = even parity, 0 = odd parity |
| rdStrobe | input | 1 | CPU read of the receive buffer |
| errClear | input | 1 | CPU read of status, clears the error flags |
| rxData | output | 8 | Receive buffer, right-justified |
| dataReady | output | 1 | A character is waiting in the buffer |
| overrunErr | output | 1 | A character overwrote an unread one |
| parityErr | output | 1 | Parity mismatch seen |
| framingErr | output | 1 | Stop bit sampled low |
| breakInt | output | 1 | Whole frame sampled low |

## Verification
Two events can land on the same clock edge: a character completing at the middle of its stop bit, and a CPU strobe, either a buffer read or a status clear. The bench counts clocks from the start-bit edge and places `rdStrobe` exactly on the completion edge. It then judges that `dataReady` stays high, `overrunErr` stays low and the buffer holds the new character. It also places `errClear` on the completion edge of a frame with a bad parity bit and expects `parityErr` to remain set.

// File: rtl/rx_pkg.sv
package rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxState_t;

  // Strobes from the sequencer to the datapath, each one cycle wide
  typedef struct packed {
    logic clearAcc;    // start bit accepted: reset accumulators
    logic takeData;    // sample a data bit now
    logic takeParity;  // sample the parity bit now
    logic finish;      // sample the stop bit and commit the character
  } rxStb_t;

endpackage

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rx_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int MAX_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       serialIn,
  input  logic [1:0] wordLen,
  input  logic       parityOn,
  output rxStb_t     stb
);

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(MAX_BITS);
  localparam int HALF  = OVS / 2;

  rxState_t          state;
  logic [CNT_W-1:0]  tickCnt;
  logic [IDX_W-1:0]  bitIdx;
  logic [IDX_W-1:0]  lastIdx;
  logic              midStart;
  logic              fullBit;

  assign lastIdx  = IDX_W'(MAX_BITS - 4) + IDX_W'(wordLen);
  assign midStart = (tickCnt == CNT_W'(HALF - 1));
  assign fullBit  = (tickCnt == CNT_W'(OVS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (tickEn) begin
      case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          if (!serialIn) state <= ST_START;
        end
        ST_START: begin
          if (midStart) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            state   <= serialIn ? ST_IDLE : ST_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (fullBit) begin
            tickCnt <= '0;
            if (bitIdx == lastIdx) state <= parityOn ? ST_PARITY : ST_STOP;
            else                   bitIdx <= bitIdx + 1'b1;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_PARITY: begin
          if (fullBit) begin
            tickCnt <= '0;
            state   <= ST_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (fullBit) begin
            tickCnt <= '0;
            state   <= ST_IDLE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb            = '0;
    stb.clearAcc   = tickEn && (state == ST_START) && midStart && !serialIn;
    stb.takeData   = tickEn && (state == ST_DATA) && fullBit;
    stb.takeParity = tickEn && (state == ST_PARITY) && fullBit;
    stb.finish     = tickEn && (state == ST_STOP) && fullBit;
  end

endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import rx_pkg::*;
#(
  parameter int MAX_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serialIn,
  input  rxStb_t              stb,
  input  logic [1:0]          wordLen,
  input  logic                parityOn,
  input  logic                parityEven,
  input  logic                rdStrobe,
  input  logic                errClear,
  output logic [MAX_BITS-1:0] rxData,
  output logic                dataReady,
  output logic                overrunErr,
  output logic                parityErr,
  output logic                framingErr,
  output logic                breakInt
);

  localparam int IDX_W = $clog2(MAX_BITS);

  logic [MAX_BITS-1:0] shiftReg;
  logic                parAcc;
  logic                anyHigh;
  logic [IDX_W-1:0]    shiftAmt;
  logic [MAX_BITS-1:0] aligned;
  logic                parityBad;
  logic                stopLow;
  logic                lineBreak;
  logic                overrunNow;

  // Bits enter at the top; shorter words are moved down to bit 0
  assign shiftAmt   = IDX_W'(3) - IDX_W'(wordLen);
  assign aligned    = shiftReg >> shiftAmt;
  assign parityBad  = parityOn && (parAcc == parityEven);
  assign stopLow    = !serialIn;
  assign lineBreak  = stopLow && !anyHigh;
  assign overrunNow = dataReady && !rdStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      anyHigh  <= 1'b0;
    end else if (stb.clearAcc) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
      anyHigh  <= 1'b0;
    end else if (stb.takeData) begin
      shiftReg <= {serialIn, shiftReg[MAX_BITS-1:1]};
      parAcc   <= parAcc ^ serialIn;
      anyHigh  <= anyHigh | serialIn;
    end else if (stb.takeParity) begin
      parAcc   <= parAcc ^ serialIn;
      anyHigh  <= anyHigh | serialIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData     <= '0;
      dataReady  <= 1'b0;
      overrunErr <= 1'b0;
      parityErr  <= 1'b0;
      framingErr <= 1'b0;
      breakInt   <= 1'b0;
    end else begin
      if (stb.finish) begin
        rxData    <= aligned;
        dataReady <= 1'b1;
      end else if (rdStrobe) begin
        dataReady <= 1'b0;
      end
      overrunErr <= (stb.finish && overrunNow) || (overrunErr && !errClear);
      parityErr  <= (stb.finish && parityBad)  || (parityErr  && !errClear);
      framingErr <= (stb.finish && stopLow)    || (framingErr && !errClear);
      breakInt   <= (stb.finish && lineBreak)  || (breakInt   && !errClear);
    end
  end

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import rx_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int MAX_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                serialIn,
  input  logic [1:0]          wordLen,
  input  logic                parityOn,
  input  logic                parityEven,
  input  logic                rdStrobe,
  input  logic                errClear,
  output logic [MAX_BITS-1:0] rxData,
  output logic                dataReady,
  output logic                overrunErr,
  output logic                parityErr,
  output logic                framingErr,
  output logic                breakInt
);

  rxStb_t ctlStb;
  logic   charDone;

  assign charDone = ctlStb.finish;

  rx_ctrl #(.OVS(OVS), .MAX_BITS(MAX_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .serialIn (serialIn),
    .wordLen  (wordLen),
    .parityOn (parityOn),
    .stb      (ctlStb)
  );

  rx_datapath #(.MAX_BITS(MAX_BITS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .serialIn   (serialIn),
    .stb        (ctlStb),
    .wordLen    (wordLen),
    .parityOn   (parityOn),
    .parityEven (parityEven),
    .rdStrobe   (rdStrobe),
    .errClear   (errClear),
    .rxData     (rxData),
    .dataReady  (dataReady),
    .overrunErr (overrunErr),
    .parityErr  (parityErr),
    .framingErr (framingErr),
    .breakInt   (breakInt)
  );

endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              rdStrobe,
  input logic              errClear,
  input logic              charDone,
  input logic [DATA_W-1:0] rxData,
  input logic              dataReady,
  input logic              overrunErr,
  input logic              framingErr,
  input logic              breakInt
);

  AST_DR_AFTER_CHAR: assert property (@(posedge clk) disable iff (!rstN)
    charDone |=> dataReady); // R8

  AST_DR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (dataReady && rdStrobe && !charDone) |=> !dataReady); // R8

  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (charDone && dataReady && !rdStrobe) |=> overrunErr); // R9

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrunErr && !errClear) |=> overrunErr); // R10

  AST_BREAK_IMPLIES_FRAMING: assert property (@(posedge clk) disable iff (!rstN)
    breakInt |-> framingErr); // R7

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(rxData)); // R11

endmodule

bind uart_rx_core uart_rx_core_chk #(.DATA_W(MAX_BITS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .tickEn     (tickEn),
  .rdStrobe   (rdStrobe),
  .errClear   (errClear),
  .charDone   (charDone),
  .rxData     (rxData),
  .dataReady  (dataReady),
  .overrunErr (overrunErr),
  .framingErr (framingErr),
  .breakInt   (breakInt)
);

// File: tb/sim_uart_rx_core.sv
module sim_uart_rx_core;

  logic       clk = 1'b0;
  logic       rstN;
  logic       tickEn;
  logic       serialIn;
  logic [1:0] wordLen;
  logic       parityOn;
  logic       parityEven;
  logic       rdStrobe;
  logic       errClear;
  logic [7:0] rxData;
  logic       dataReady, overrunErr, parityErr, framingErr, breakInt;

  int checks = 0;
  int fails  = 0;
  int tickDiv = 1;
  int divCnt  = 0;

  always #5 clk = ~clk;

  always @(negedge clk) divCnt <= (divCnt + 1 >= tickDiv) ? 0 : divCnt + 1;
  assign tickEn = (divCnt == 0);

  uart_rx_core u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .serialIn(serialIn),
    .wordLen(wordLen), .parityOn(parityOn), .parityEven(parityEven),
    .rdStrobe(rdStrobe), .errClear(errClear), .rxData(rxData),
    .dataReady(dataReady), .overrunErr(overrunErr), .parityErr(parityErr),
    .framingErr(framingErr), .breakInt(breakInt)
  );

  // {wordLen[1:0], parityOn, parityEven, corruptParity, stopHigh, 2'b00, data[7:0]}
  localparam logic [15:0] VEC [8] = '{
    16'hC4A5, 16'h3413, 16'h642C, 16'hBC55,
    16'hE400, 16'hC03C, 16'hF000, 16'h04FF
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic rdV, input logic clrV);
    rdStrobe = rdV;
    errClear = clrV;
    @(negedge clk);
    rdStrobe = 1'b0;
    errClear = 1'b0;
  endtask

  task automatic holdBit(input logic v, input bit noise);
    if (noise) begin
      serialIn = !v;
      repeat (4) @(negedge clk);
      serialIn = v;
      repeat (8) @(negedge clk);
      serialIn = !v;
      repeat (4) @(negedge clk);
    end else begin
      serialIn = v;
      repeat (16 * tickDiv) @(negedge clk);
    end
  endtask

  task automatic sendFrame(input logic [1:0] wl, input logic pOn, input logic pEven,
                           input logic corrupt, input logic stopHigh, input logic [7:0] data,
                           input bit noise, input bit pulseRd, input bit pulseClr);
    logic [7:0] msk;
    logic       pBit;
    int         nb;
    nb   = 5 + int'(wl);
    msk  = 8'((1 << nb) - 1);
    pBit = (^(data & msk)) ^ !pEven ^ corrupt;
    @(negedge clk);
    wordLen = wl; parityOn = pOn; parityEven = pEven;
    holdBit(1'b0, 1'b0);
    for (int k = 0; k < nb; k++) holdBit(data[k], noise);
    if (pOn) holdBit(pBit, 1'b0);
    if (pulseRd || pulseClr) begin
      serialIn = stopHigh;
      repeat (8) @(negedge clk);
      rdStrobe = pulseRd;
      errClear = pulseClr;
      @(negedge clk);
      rdStrobe = 1'b0;
      errClear = 1'b0;
      repeat (7) @(negedge clk);
    end else begin
      holdBit(stopHigh, 1'b0);
    end
    serialIn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic clearAll();
    strobe(1'b1, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; serialIn = 1'b1; wordLen = 2'd3; parityOn = 1'b0;
    parityEven = 1'b0; rdStrobe = 1'b0; errClear = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 rxData in reset", rxData, 0);
    check("R1 flags in reset",
          {dataReady, overrunErr, parityErr, framingErr, breakInt}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 flags after release",
          {dataReady, overrunErr, parityErr, framingErr, breakInt}, 0);

    // Table walk: R4 width, R5 parity, R6 framing, R7 break, R8 ready
    for (int i = 0; i < 8; i++) begin
      logic [15:0] v;
      logic [7:0]  msk, md;
      logic        pSent, expBrk;
      v      = VEC[i];
      msk    = 8'((1 << (5 + int'(v[15:14]))) - 1);
      md     = v[7:0] & msk;
      pSent  = (^md) ^ !v[12] ^ v[11];
      expBrk = (md == 0) && (!v[13] || !pSent) && !v[10];
      sendFrame(v[15:14], v[13], v[12], v[11], v[10], v[7:0], 0, 0, 0);
      check("R4 rxData", rxData, md);
      check("R8 dataReady set", dataReady, 1);
      check("R5 parityErr", parityErr, v[13] && v[11]);
      check("R6 framingErr", framingErr, !v[10]);
      check("R7 breakInt", breakInt, expBrk);
      check("R9 no overrun", overrunErr, 0);
      clearAll();
      check("R8 dataReady cleared", dataReady, 0);
      check("R10 flags cleared", {overrunErr, parityErr, framingErr, breakInt}, 0);
    end

    // R2: short low glitch is rejected
    @(negedge clk);
    serialIn = 1'b0;
    repeat (4) @(negedge clk);
    serialIn = 1'b1;
    repeat (40) @(negedge clk);
    check("R2 glitch gives no character", dataReady, 0);
    sendFrame(2'd3, 0, 0, 0, 1, 8'h5A, 0, 0, 0);
    check("R2 next frame received", rxData, 8'h5A);
    clearAll();

    // R3: noise near bit edges
    sendFrame(2'd3, 0, 0, 0, 1, 8'h96, 1, 0, 0);
    check("R3 mid-bit sampling", rxData, 8'h96);
    check("R3 no parity error", parityErr, 0);
    clearAll();

    // R11: ticks every third clock
    tickDiv = 3;
    sendFrame(2'd2, 1, 1, 0, 1, 8'h4B, 0, 0, 0);
    check("R11 divided ticks data", rxData, 8'h4B);
    check("R11 divided ticks parity", parityErr, 0);
    check("R11 divided ticks ready", dataReady, 1);
    tickDiv = 1;
    repeat (4) @(negedge clk);
    clearAll();

    // R9 overrun, R10 read does not clear errors
    sendFrame(2'd3, 0, 0, 0, 1, 8'h11, 0, 0, 0);
    sendFrame(2'd3, 0, 0, 0, 1, 8'h22, 0, 0, 0);
    check("R9 overrun set", overrunErr, 1);
    check("R9 buffer overwritten", rxData, 8'h22);
    strobe(1'b1, 1'b0);
    check("R10 read keeps overrun", overrunErr, 1);
    check("R8 read clears ready", dataReady, 0);
    strobe(1'b0, 1'b1);
    check("R10 clear drops overrun", overrunErr, 0);

    // R8/R9: read on the completion edge
    sendFrame(2'd3, 0, 0, 0, 1, 8'h33, 0, 0, 0);
    sendFrame(2'd3, 0, 0, 0, 1, 8'h44, 0, 1, 0);
    check("R8 ready kept on coincident read", dataReady, 1);
    check("R9 no overrun on coincident read", overrunErr, 0);
    check("R9 new character in buffer", rxData, 8'h44);
    clearAll();

    // R10: clear on the completion edge of a bad-parity frame
    sendFrame(2'd3, 1, 1, 1, 1, 8'h0F, 0, 0, 1);
    check("R10 set wins over clear", parityErr, 1);
    clearAll();
    check("R10 parity cleared", parityErr, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule